// File: doc/BRIEF.md
# Packed Two-Entry Colour Palette

This block is the colour lookup table of a display pipeline running in an indexed pixel mode. It holds 256 colour entries of 16 bits each. A 32-bit register bus programs them two at a time, because every bus word carries a pair of entries. Software writes and reads the raw words through a window in the block's address space. Bus accesses that fall outside that window touch no storage.

A separate lookup port serves the pixel path. It takes an 8-bit colour index and, one clock later, returns a 24-bit colour with a valid strobe. The block widens each 5-bit colour field of the selected entry to 8 bits. Each entry also carries an intensity flag. Software can store and read back this flag, but it never alters the colour that the lookup produces.

Top module: `palette_lut`

## Requirements
- R1: The palette window covers byte addresses 0x200 up to and including 0x3FC. A bus access in the window selects word n = (address − 0x200) >> 2. Address bits [1:0] take no part in the selection.
- R2: A bus read in the window returns the raw 32-bit word last written to word n. The data and `bus_rvalid` appear in the cycle after the read request.
- R3: A bus write outside the window changes no stored word. A bus read outside the window returns zero, with `bus_rvalid` high.
- R4: Word n holds entry 2n in bits [15:0] and entry 2n+1 in bits [31:16]. Bit 0 of the lookup index selects the half: 0 selects the low half and 1 selects the high half.
- R5: Within an entry, red is bits [4:0], green is bits [9:5] and blue is bits [14:10]. Each 8-bit output channel equals its 5-bit field shifted left by 3, so its three low bits are zero.
- R6: Entry bit 15 is an intensity flag. It is stored and read back unchanged, and it has no effect on the colour outputs.
- R7: `px_valid` is `lk_valid` delayed by exactly one cycle. The colour outputs belong to the index presented in the previous cycle.
- R8: When a bus write and a lookup address the same word in the same cycle, the lookup returns the colour of the word as it was before the write.
- R9: While `rst` is high, at the next clock edge `px_valid` and `bus_rvalid` go low and `bus_rdata` reads zero. Stored words have no defined value after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Bus access request this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data strobe, one cycle after a read |
| lk_valid | input | 1 | Lookup request |
| lk_index | input | 8 | Colour index |
| px_valid | output | 1 | Colour result strobe |
| px_red | output | 8 | Red channel |
| px_green | output | 8 | Green channel |
| px_blue | output | 8 | Blue channel |

## Verification
The hardest case to reach from the ports is a bus write and a lookup that land on the same storage word in the same cycle. Only that alignment shows whether the lookup reads the word before or after the update. The bench drives both requests on one clock edge, with different old and new contents. It checks for the old colour first, then looks up the same index again to confirm the new colour. The bench also pairs two entries that differ only in the intensity flag, and confirms that they give equal colours but different read-back words.

// File: rtl/palette_pkg.sv
package palette_pkg;

    localparam int BUS_W   = 32;
    localparam int ENTRY_W = 16;
    localparam int COMP_W  = 5;
    localparam int CHAN_W  = 8;
    localparam int PAD_W   = CHAN_W - COMP_W;

    // One 16-bit palette entry; field positions are fixed by the programming model.
    typedef struct packed {
        logic              intensity;
        logic [COMP_W-1:0] blue;
        logic [COMP_W-1:0] green;
        logic [COMP_W-1:0] red;
    } entry_t;

    typedef struct packed {
        logic [CHAN_W-1:0] r;
        logic [CHAN_W-1:0] g;
        logic [CHAN_W-1:0] b;
    } rgb_t;

    function automatic logic [CHAN_W-1:0] widen(input logic [COMP_W-1:0] c);
        return {c, {PAD_W{1'b0}}};
    endfunction

    function automatic rgb_t expand_entry(input entry_t e);
        rgb_t o;
        o.r = widen(e.red);
        o.g = widen(e.green);
        o.b = widen(e.blue);
        return o;
    endfunction

endpackage

// File: rtl/palette_decode.sv
module palette_decode #(
    parameter int ADDR_W    = 12,
    parameter int BASE_ADDR = 'h200,
    parameter int WORDS     = 128,
    localparam int WIDX_W   = $clog2(WORDS)
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit,
    output logic [WIDX_W-1:0] word_idx
);
    localparam logic [ADDR_W:0] LO = (ADDR_W+1)'(BASE_ADDR);
    localparam logic [ADDR_W:0] HI = (ADDR_W+1)'(BASE_ADDR + WORDS * 4);

    logic [ADDR_W:0] ext;
    logic [ADDR_W:0] offs;

    always_comb begin
        ext      = {1'b0, addr};
        offs     = ext - LO;
        hit      = (ext >= LO) && (ext < HI);
        word_idx = offs[WIDX_W+1:2];
    end
endmodule

// File: rtl/palette_store.sv
module palette_store #(
    parameter int WORDS   = 128,
    parameter int WORD_W  = 32,
    localparam int WIDX_W = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [WIDX_W-1:0] wr_idx,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [WIDX_W-1:0] rd_idx,
    output logic [WORD_W-1:0] rd_data,
    input  logic              lk_en,
    input  logic [WIDX_W-1:0] lk_idx,
    output logic [WORD_W-1:0] lk_data
);
    logic [WORD_W-1:0] mem [WORDS];

    // Both read ports sample before the write lands: read-old on collision.
    always_ff @(posedge clk) begin
        if (wr_en)
            mem[wr_idx] <= wr_data;
        if (rd_en)
            rd_data <= mem[rd_idx];
        if (lk_en)
            lk_data <= mem[lk_idx];
    end
endmodule

// File: rtl/palette_colour.sv
module palette_colour
    import palette_pkg::*;
(
    input  logic [BUS_W-1:0] word,
    input  logic             upper,
    output rgb_t             colour
);
    entry_t halves [2];

    always_comb begin
        for (int h = 0; h < 2; h++)
            halves[h] = entry_t'(word[h*ENTRY_W +: ENTRY_W]);
        colour = expand_entry(halves[upper]);
    end
endmodule

// File: rtl/palette_lut.sv
module palette_lut
    import palette_pkg::*;
#(
    parameter int ADDR_W    = 12,
    parameter int BASE_ADDR = 'h200,
    parameter int ENTRIES   = 256,
    localparam int WORDS    = ENTRIES / 2,
    localparam int WIDX_W   = $clog2(WORDS),
    localparam int IDX_W    = WIDX_W + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    output logic              bus_rvalid,
    input  logic              lk_valid,
    input  logic [IDX_W-1:0]  lk_index,
    output logic              px_valid,
    output logic [CHAN_W-1:0] px_red,
    output logic [CHAN_W-1:0] px_green,
    output logic [CHAN_W-1:0] px_blue
);
    logic              win_hit;
    logic [WIDX_W-1:0] win_idx;
    logic              wr_go, rd_go;
    logic              rd_hit_q;
    logic              upper_q;
    logic [BUS_W-1:0]  store_rd, store_lk;
    rgb_t              colour;

    palette_decode #(
        .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR), .WORDS(WORDS)
    ) u_decode (
        .addr(bus_addr), .hit(win_hit), .word_idx(win_idx)
    );

    always_comb begin
        wr_go = bus_sel && bus_wr && win_hit;
        rd_go = bus_sel && !bus_wr && win_hit;
    end

    palette_store #(
        .WORDS(WORDS), .WORD_W(BUS_W)
    ) u_store (
        .clk(clk),
        .wr_en(wr_go), .wr_idx(win_idx), .wr_data(bus_wdata),
        .rd_en(rd_go), .rd_idx(win_idx), .rd_data(store_rd),
        .lk_en(lk_valid), .lk_idx(lk_index[IDX_W-1:1]), .lk_data(store_lk)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rvalid <= 1'b0;
            rd_hit_q   <= 1'b0;
            px_valid   <= 1'b0;
            upper_q    <= 1'b0;
        end else begin
            bus_rvalid <= bus_sel && !bus_wr;
            rd_hit_q   <= rd_go;
            px_valid   <= lk_valid;
            if (lk_valid)
                upper_q <= lk_index[0];
        end
    end

    assign bus_rdata = rd_hit_q ? store_rd : '0;

    palette_colour u_colour (
        .word(store_lk), .upper(upper_q), .colour(colour)
    );

    assign px_red   = colour.r;
    assign px_green = colour.g;
    assign px_blue  = colour.b;

    assert_lookup_strobe_R7: assert property (@(posedge clk) disable iff (rst)
        lk_valid |=> px_valid);
    assert_lookup_idle_R7: assert property (@(posedge clk) disable iff (rst)
        !lk_valid |=> !px_valid);
    assert_read_strobe_R2: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && !bus_wr) |=> bus_rvalid);
    assert_write_no_strobe_R2: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && bus_wr) |=> !bus_rvalid);
    assert_outside_read_zero_R3: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && !bus_wr && !win_hit) |=> (bus_rdata == '0));
    assert_reset_quiet_R9: assert property (@(posedge clk)
        rst |=> (!px_valid && !bus_rvalid && bus_rdata == '0));
endmodule

// File: tb/sim_palette_lut.sv
`timescale 1ns/1ps
module sim_palette_lut;
    logic        clk = 1'b0;
    logic        rst;
    logic        bus_sel, bus_wr;
    logic [11:0] bus_addr;
    logic [31:0] bus_wdata, bus_rdata;
    logic        bus_rvalid;
    logic        lk_valid;
    logic [7:0]  lk_index;
    logic        px_valid;
    logic [7:0]  px_red, px_green, px_blue;

    int total = 0;
    int failed = 0;
    bit done = 0;
    logic [31:0] model [128];

    always #2.5 clk = ~clk;

    palette_lut u0 (
        .clk(clk), .rst(rst),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
        .lk_valid(lk_valid), .lk_index(lk_index),
        .px_valid(px_valid), .px_red(px_red), .px_green(px_green), .px_blue(px_blue)
    );

    function automatic logic [31:0] pattern(input int n);
        logic [31:0] v;
        v = 32'(n) * 32'h9E3779B1;
        return v ^ 32'h00A55A00;
    endfunction

    function automatic logic [23:0] exp_rgb(input logic [31:0] w, input logic odd);
        logic [15:0] e;
        e = odd ? w[31:16] : w[15:0];
        return {e[4:0], 3'b000, e[9:5], 3'b000, e[14:10], 3'b000};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            failed++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [11:0] a, output logic [31:0] d, output logic v);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_sel = 1'b0;
        d = bus_rdata; v = bus_rvalid;
    endtask

    task automatic lookup(input logic [7:0] idx, output logic [23:0] c, output logic v);
        @(negedge clk);
        lk_valid = 1'b1; lk_index = idx;
        @(negedge clk);
        lk_valid = 1'b0;
        c = {px_red, px_green, px_blue}; v = px_valid;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failed++; total++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", total - failed, total);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        logic        v;
        logic [23:0] c, c2;
        rst = 1'b1; bus_sel = 0; bus_wr = 0; bus_addr = 0; bus_wdata = 0;
        lk_valid = 0; lk_index = 0;
        repeat (4) @(negedge clk);
        chk("R9 px_valid", 32'(px_valid), 0);
        chk("R9 bus_rvalid", 32'(bus_rvalid), 0);
        chk("R9 bus_rdata", bus_rdata, 0);
        rst = 1'b0;

        // R1/R2: fill every word, read each back.
        for (int n = 0; n < 128; n++) begin
            model[n] = pattern(n);
            bus_write(12'(32'h200 + 4 * n), model[n]);
        end
        for (int n = 0; n < 128; n++) begin
            bus_read(12'(32'h200 + 4 * n), d, v);
            chk("R2 rvalid", 32'(v), 1);
            chk("R1 R2 readback", d, model[n]);
        end

        // R4/R5/R7: every index.
        for (int i = 0; i < 256; i++) begin
            lookup(8'(i), c, v);
            chk("R7 px_valid", 32'(v), 1);
            chk("R4 R5 colour", 32'(c), 32'(exp_rgb(model[i/2], i[0])));
        end
        @(negedge clk);
        chk("R7 px_valid idle", 32'(px_valid), 0);

        // R1: low address bits ignored.
        model[3] = 32'hCAFE_1357;
        bus_write(12'h20E, model[3]);
        bus_read(12'h20D, d, v);
        chk("R1 low bits", d, model[3]);

        // R3: outside window.
        bus_write(12'h1FC, 32'hDEAD_BEEF);
        bus_write(12'h400, 32'hFEED_F00D);
        bus_read(12'h200, d, v);
        chk("R3 word0 untouched", d, model[0]);
        bus_read(12'h3FC, d, v);
        chk("R3 word127 untouched", d, model[127]);
        bus_read(12'h100, d, v);
        chk("R3 outside read rvalid", 32'(v), 1);
        chk("R3 outside read zero", d, 0);
        bus_read(12'h400, d, v);
        chk("R3 read above window zero", d, 0);

        // R6: intensity flag.
        model[7] = {16'h8000 | 16'h2B6D, 16'h2B6D};
        bus_write(12'h21C, model[7]);
        bus_read(12'h21C, d, v);
        chk("R6 flag read back", d, model[7]);
        lookup(8'd14, c, v);
        lookup(8'd15, c2, v);
        chk("R6 flag no colour effect", 32'(c2), 32'(c));
        chk("R6 colour value", 32'(c), 32'(exp_rgb(model[7], 1'b0)));

        // R8: write and lookup same word same cycle.
        @(negedge clk);
        bus_sel = 1; bus_wr = 1; bus_addr = 12'h224; bus_wdata = 32'h7C1F_03E0;
        lk_valid = 1; lk_index = 8'd18;
        @(negedge clk);
        bus_sel = 0; bus_wr = 0; lk_valid = 0;
        chk("R8 old colour on collision", 32'({px_red, px_green, px_blue}),
            32'(exp_rgb(model[9], 1'b0)));
        model[9] = 32'h7C1F_03E0;
        lookup(8'd18, c, v);
        chk("R8 new colour after", 32'(c), 32'(exp_rgb(model[9], 1'b0)));
        lookup(8'd19, c, v);
        chk("R4 upper half after", 32'(c), 32'(exp_rgb(model[9], 1'b1)));

        // R9: reset mid-run.
        @(negedge clk);
        bus_sel = 1; bus_wr = 0; bus_addr = 12'h200; lk_valid = 1; rst = 1;
        @(negedge clk);
        bus_sel = 0; lk_valid = 0; rst = 0;
        chk("R9 rvalid after reset", 32'(bus_rvalid), 0);
        chk("R9 px_valid after reset", 32'(px_valid), 0);
        chk("R9 rdata after reset", bus_rdata, 0);

        done = 1;
        $display("%0d/%0d checks passed", total - failed, total);
        $finish;
    end
endmodule